// File: doc/BRIEF.md
# Locked-Feed Watchdog Timer

This watchdog runs from its own clock. A fixed divide-by-four prescaler paces a 24-bit down-counter. If software does not feed it before the counter runs out, the watchdog raises a watchdog event. Depending on a mode bit, the event is either a one-cycle system reset request or a level interrupt. A badly formed feed while the watchdog is enabled raises the same event at once.

Software reaches four registers through a simple single-cycle register port: control, timeout constant, feed and cause status. A fifth read-only address shows the live count. Reads are combinational on `rd_addr`. Writes take effect at the clock edge where `wr_en` is high.

The enable bit can only be set by software. Once set, it clears only on a reset or on a watchdog event. The block has two reset inputs:
- `sys_rst_n` is the system reset. The reset controller drives it when it acts on the request. It clears everything except the cause flag.
- `por_n` is power-on reset. It also clears the cause flag.

Top module: `wdt_feedlock`

## Requirements
- R1: After a valid feed completes at clock edge F, the counter is reloaded with the timeout constant TC. It then drops by one on every fourth edge. The watchdog event fires at edge F + 4*(TC+1) if no further feed arrives. From edge F + k, the count reads TC - floor(k/4).
- R2: The timeout constant sits at address 1, bits 23:0. A written value below 0xFF is stored as 0xFF. Any other value is stored as written. The reset value is 0xFF.
- R3: Control register, address 0:
  - bit0 is enable, bit1 is reset-mode, bit2 is the timeout flag.
  - Writing 0 to bit0 does not clear the enable.
  - Only a watchdog event, `sys_rst_n` or `por_n` clears the enable.
- R4: After enable and before the first valid feed, the counter does not move and no timeout occurs.
- R5: In interrupt mode (bit1 = 0), a watchdog event sets the timeout flag and drives `irq_o` high. Both stay high until a control write with bit2 = 1.
- R6: A valid feed is two consecutive register writes to address 2: low byte 0xAA, then low byte 0x55. While enabled, it reloads the counter and restarts the prescaler. The first valid feed after enabling starts the counting. Feeds while disabled have no effect.
- R7: While enabled, any of the following fires a watchdog event at the edge of the offending write:
  - a feed write whose low byte is neither 0xAA nor 0x55;
  - 0x55 without a preceding 0xAA;
  - 0xAA directly after 0xAA;
  - any write to another address between 0xAA and 0x55.
- R8: In reset mode (bit1 = 1), a watchdog event drives `rst_req_o` high for exactly one cycle. It also sets the cause flag, read at address 3, bit0.
- R9: The cause flag survives `sys_rst_n`. It is cleared by `por_n` or by any write to address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| sys_rst_n | input | 1 | System reset, active low, keeps the cause flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 ctrl, 1 timeout, 2 feed, 3 status) |
| wr_data | input | 32 | Write data |
| rd_addr | input | 3 | Read address (0 to 3 as above, 4 live count) |
| rd_data | output | 32 | Read data, combinational |
| rst_req_o | output | 1 | One-cycle system reset request |
| irq_o | output | 1 | Timeout interrupt, level |
| wdt_cause_o | output | 1 | Last reset came from the watchdog |

## Verification
A corrupted feed-sequence state shows at the ports on the very next feed write. Either a spurious event fires at that edge, or an expected one is missing. A prescaler or counter fault moves the event edge away from F + 4*(TC+1), and the live-count read exposes the drift within four cycles of a feed. A faulty enable or cause-flag hold shows up on the first control or status read after a write, an event or a system reset.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_TC    = 3'd1;
  localparam logic [ADDR_W-1:0] A_FEED  = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd3;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd4;

  localparam logic [7:0] FEED_ARM  = 8'hAA;
  localparam logic [7:0] FEED_FIRE = 8'h55;

  localparam int CB_EN   = 0;
  localparam int CB_RMOD = 1;
  localparam int CB_TO   = 2;
endpackage

// File: rtl/wdt_feed_seq.sv
module wdt_feed_seq
  import wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       is_feed,
  input  logic [7:0] data,
  output logic       feed_ok,
  output logic       feed_bad
);
  logic armed_q;
  logic is_arm, is_fire;

  assign is_arm  = (data == FEED_ARM);
  assign is_fire = (data == FEED_FIRE);

  always_comb begin
    feed_ok  = wr_en & is_feed & is_fire & armed_q;
    feed_bad = 1'b0;
    if (wr_en) begin
      if (is_feed)
        feed_bad = !((is_arm && !armed_q) || (is_fire && armed_q));
      else
        feed_bad = armed_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     armed_q <= 1'b0;
    else if (wr_en) armed_q <= is_feed & is_arm & ~armed_q;
  end
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
  parameter int CNT_W = 24,
  parameter int PRE_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick   = run & (&pre_q);
  assign expire = tick & ~load & (cnt_q == '0);
  assign cnt    = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      pre_q <= '0;
      cnt_q <= load_val;
    end else if (run) begin
      pre_q <= pre_q + 1'b1;
      if (tick && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/wdt_feedlock.sv
module wdt_feedlock
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int PRE_W  = 2,
  parameter int TC_MIN = 255
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rst_req_o,
  output logic              irq_o,
  output logic              wdt_cause_o
);
  localparam logic [CNT_W-1:0] TC_FLOOR = CNT_W'(TC_MIN);
  localparam int               PAD_W    = DATA_W - CNT_W;

  logic             rst_n;
  logic             en_q, rmod_q, to_q, run_q, rst_req_q, cause_q;
  logic [CNT_W-1:0] tc_q, cnt;
  logic             feed_ok, feed_bad, expire, evt, load, ctrl_clr;
  logic             wr_ctrl, wr_tc, wr_stat;

  assign rst_n   = sys_rst_n & por_n;
  assign wr_ctrl = wr_en && wr_addr == A_CTRL;
  assign wr_tc   = wr_en && wr_addr == A_TC;
  assign wr_stat = wr_en && wr_addr == A_STAT;
  assign ctrl_clr = wr_ctrl & wr_data[CB_TO];

  wdt_feed_seq u_feed (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .is_feed (wr_addr == A_FEED),
    .data    (wr_data[7:0]),
    .feed_ok (feed_ok),
    .feed_bad(feed_bad)
  );

  assign load = feed_ok & en_q;

  wdt_countdown #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run_q),
    .load    (load),
    .load_val(tc_q),
    .cnt     (cnt),
    .expire  (expire)
  );

  assign evt = en_q & (expire | feed_bad);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      rmod_q    <= 1'b0;
      to_q      <= 1'b0;
      run_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else if (evt) begin
      en_q      <= 1'b0;
      run_q     <= 1'b0;
      to_q      <= 1'b1;
      rst_req_q <= rmod_q;
    end else begin
      rst_req_q <= 1'b0;
      if (wr_ctrl) begin
        en_q   <= en_q | wr_data[CB_EN];
        rmod_q <= wr_data[CB_RMOD];
      end
      if (ctrl_clr) to_q <= 1'b0;
      if (load) run_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     tc_q <= TC_FLOOR;
    else if (wr_tc) tc_q <= (wr_data[CNT_W-1:0] < TC_FLOOR) ? TC_FLOOR : wr_data[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)               cause_q <= 1'b0;
    else if (evt && rmod_q)   cause_q <= 1'b1;
    else if (wr_stat)         cause_q <= 1'b0;
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:  rd_data[2:0] = {to_q, rmod_q, en_q};
      A_TC:    rd_data = {{PAD_W{1'b0}}, tc_q};
      A_STAT:  rd_data[0] = cause_q;
      A_COUNT: rd_data = {{PAD_W{1'b0}}, cnt};
      default: rd_data = '0;
    endcase
  end

  assign rst_req_o   = rst_req_q;
  assign irq_o       = to_q & ~rmod_q;
  assign wdt_cause_o = cause_q;
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk #(
  parameter int CNT_W  = 24,
  parameter int TC_MIN = 255
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_q,
  input logic             evt,
  input logic             run_q,
  input logic             load,
  input logic             feed_bad,
  input logic             ctrl_clr,
  input logic             to_q,
  input logic             rst_req_o,
  input logic             wdt_cause_o,
  input logic [CNT_W-1:0] tc_q,
  input logic [CNT_W-1:0] cnt
);
  a_r1_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_q) && !$past(load) && cnt != $past(cnt)) |-> cnt == $past(cnt) - 1'b1);

  a_r2_tc_floor: assert property (@(posedge clk) disable iff (!rst_n)
    tc_q >= CNT_W'(TC_MIN));

  a_r3_enable_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_q) |-> $past(evt));

  a_r5_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (to_q && !ctrl_clr) |=> to_q);

  a_r7_bad_feed_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && feed_bad) |=> (rst_req_o || to_q));

  a_r8_cause_on_req: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> wdt_cause_o);

  a_r8_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);
endmodule

bind wdt_feedlock wdt_chk #(.CNT_W(CNT_W), .TC_MIN(TC_MIN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_q       (en_q),
  .evt        (evt),
  .run_q      (run_q),
  .load       (load),
  .feed_bad   (feed_bad),
  .ctrl_clr   (ctrl_clr),
  .to_q       (to_q),
  .rst_req_o  (rst_req_o),
  .wdt_cause_o(wdt_cause_o),
  .tc_q       (tc_q),
  .cnt        (cnt)
);

// File: tb/wdt_feedlock_tb.sv
module wdt_feedlock_tb;
  logic        clk = 1'b0;
  logic        por_n = 1'b0, sys_rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rst_req_o, irq_o, wdt_cause_o;

  int checks = 0, errors = 0, cyc = 0, last_wr = 0;
  int exp_cyc[$];
  int exp_kind[$];
  logic prev_evt = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_feedlock u_dut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .rst_req_o(rst_req_o), .irq_o(irq_o), .wdt_cause_o(wdt_cause_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    last_wr = cyc;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr = a; #1;
    d = rd_data;
  endtask

  // driver: push expected event (edge index, kind 1 = reset, 2 = irq)
  task automatic expect_evt(input int at, input int kind);
    exp_cyc.push_back(at);
    exp_kind.push_back(kind);
  endtask

  task automatic feed();
    wr(3'd2, 32'hAA);
    wr(3'd2, 32'h55);
  endtask

  task automatic drain(input int limit);
    for (int i = 0; i < limit && exp_cyc.size() != 0; i++) @(posedge clk);
    check("R1 scoreboard drained", exp_cyc.size(), 0);
  endtask

  // monitor: pop and compare on each rising event
  always @(negedge clk) begin
    logic now_evt;
    now_evt = rst_req_o | irq_o;
    if (now_evt && !prev_evt) begin
      checks++;
      if (exp_cyc.size() == 0) begin
        errors++;
        $display("FAIL R4 unexpected event actual=%0d expected=none", cyc);
      end else begin
        int ec, ek, k;
        ec = exp_cyc.pop_front();
        ek = exp_kind.pop_front();
        k = rst_req_o ? 1 : 2;
        if (ec != cyc || ek != k) begin
          errors++;
          $display("FAIL R1/R7 event actual=%0d/%0d expected=%0d/%0d", cyc, k, ec, ek);
        end
      end
    end
    prev_evt = now_evt;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int f;
    repeat (3) @(posedge clk);
    @(negedge clk); por_n = 1'b1; sys_rst_n = 1'b1;

    // reset state
    rd(3'd0, v); check("R3 ctrl reset", v, 32'h0);
    rd(3'd1, v); check("R2 tc reset", v, 32'hFF);
    rd(3'd3, v); check("R9 cause reset", v, 32'h0);
    check("R8 outputs reset", {rst_req_o, irq_o, wdt_cause_o}, 3'b000);

    // R2 clamp
    wr(3'd1, 32'h10);  rd(3'd1, v); check("R2 clamp 0x10", v, 32'hFF);
    wr(3'd1, 32'hFE);  rd(3'd1, v); check("R2 clamp 0xFE", v, 32'hFF);
    wr(3'd1, 32'h100); rd(3'd1, v); check("R2 keep 0x100", v, 32'h100);

    // R6 feed while disabled has no effect
    feed();
    repeat (50) @(posedge clk);
    rd(3'd4, v); check("R6 disabled feed count", v, 32'h0);
    rd(3'd0, v); check("R6 disabled ctrl", v, 32'h0);

    // R3 sticky enable
    wr(3'd0, 32'h1); wr(3'd0, 32'h0);
    rd(3'd0, v); check("R3 enable sticky", v & 32'h1, 32'h1);

    // R4 no counting before first feed
    repeat (1200) @(posedge clk);
    rd(3'd4, v); check("R4 count frozen", v, 32'h0);

    // R1/R5 expiry in interrupt mode, TC=0x100
    wr(3'd2, 32'hAA); wr(3'd2, 32'h55);
    f = last_wr;
    expect_evt(f + 4 * (32'h100 + 1), 2);
    rd(3'd4, v); check("R6 reload on feed", v, 32'h100);
    drain(1100);
    rd(3'd0, v); check("R5 flag set, enable cleared", v, 32'h4);
    repeat (20) @(posedge clk);
    #1 check("R5 irq held", irq_o, 1'b1);
    wr(3'd0, 32'h4);
    rd(3'd0, v); check("R5 flag cleared", v, 32'h0);
    check("R5 irq low", irq_o, 1'b0);

    // R1/R6 keep-alive with TC=0x101
    wr(3'd1, 32'h101); wr(3'd0, 32'h1);
    feed();
    repeat (10) @(posedge clk);
    rd(3'd4, v); check("R1 count after 10 cycles", v, 32'h101 - 2);
    repeat (700) @(posedge clk);
    feed();
    f = last_wr;
    expect_evt(f + 4 * (32'h101 + 1), 2);
    drain(1200);
    wr(3'd0, 32'h4);

    // R7/R8 bad feed: other write between AA and 55, reset mode
    wr(3'd0, 32'h3);
    feed();
    wr(3'd2, 32'hAA);
    wr(3'd1, 32'h200);
    expect_evt(last_wr, 1);
    drain(10);
    @(negedge clk);
    check("R8 req one cycle", rst_req_o, 1'b0);
    rd(3'd3, v); check("R8 cause set", v, 32'h1);

    // R9 survives system reset
    @(negedge clk); sys_rst_n = 1'b0;
    @(negedge clk); sys_rst_n = 1'b1;
    rd(3'd3, v); check("R9 cause survives sys reset", v, 32'h1);
    rd(3'd0, v); check("R3 enable cleared by reset", v, 32'h0);
    rd(3'd1, v); check("R2 tc back to floor", v, 32'hFF);
    wr(3'd3, 32'h0);
    rd(3'd3, v); check("R9 cause cleared by write", v, 32'h0);

    // R7 wrong feed value, reset mode; then R9 power-on clear
    wr(3'd0, 32'h3);
    wr(3'd2, 32'h12);
    expect_evt(last_wr, 1);
    drain(10);
    check("R8 cause pin", wdt_cause_o, 1'b1);
    @(negedge clk); por_n = 1'b0;
    @(negedge clk); por_n = 1'b1;
    rd(3'd3, v); check("R9 cause cleared by por", v, 32'h0);

    // R7 0x55 without 0xAA, interrupt mode
    wr(3'd0, 32'h1);
    wr(3'd2, 32'h55);
    expect_evt(last_wr, 2);
    drain(10);
    #1 check("R7 irq after lone 0x55", irq_o, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule